// File: doc/BRIEF.md
# Serial Register Access Port

This block lets a serial test port reach a parallel space of up to 128 registers. Each scan through the block carries one request. The request holds a 32-bit data word, a 7-bit register address and a direction bit. When the update strobe arrives, the request goes onto a simple parallel register bus toward the target. A write request becomes a one-cycle write strobe. A read request becomes a one-cycle read strobe, and the returned word is held inside the block.

Reads are pipelined across scans. The word that appears on the serial output during a scan belongs to the read issued by the scan before it. For this reason, every read request touches the target exactly once, and registers whose reads have side effects, such as FIFO pops, behave correctly. A host finishes a read by sending one more scan. That scan is normally a read of address 0, the identification register, which is free of side effects.

The block responds only while its select input is high. The select input is driven by the surrounding test logic, which decodes the instruction and the chosen chain. While the block is not selected, the serial input passes straight to the serial output.

Top module: `scanRegPort`

## Requirements
- R1: The chain is 40 bits and shifts one bit per clock while `shiftDr` is high. The output `tdo` shows chain bit 0, and `tdi` enters at bit 39. Bits [31:0] hold the data, bits [38:32] the address and bit 39 the direction. So the host sends data LSB first, then the address LSB first, then the direction bit last.
- R2: When update fires with direction bit 1 (write), `busWrEn` is high for exactly one cycle, in the clock after the update edge. During that cycle `busAddr` and `busWrData` carry the scanned address and data, and `busRdEn` stays low.
- R3: When update fires with direction bit 0 (read), `busRdEn` is high for exactly one cycle, in the clock after the update edge, with `busAddr` set to the scanned address. The block latches `busRdData` at the end of that cycle.
- R4: On capture, chain bits [31:0] load the most recently latched read word, and bits [39:32] load zero. The following scan therefore shifts the read word out LSB first.
- R5: A write request leaves the latched read word unchanged. The scan after a write returns the word from the last earlier read.
- R6: Back-to-back reads of the same address cause exactly one bus read per scan. Each result comes out on the following scan, so a side-effecting register returns its successive values in order.
- R7: While `chainSel` is low, `tdo` equals `tdi`. Capture, shift and update strobes then have no effect: there is no bus strobe, and the latched read word is kept.
- R8: After reset there are no bus strobes, and the first capture returns zero.
- R9: If more than one strobe is high in the same cycle, capture wins over shift, and shift wins over update. At least one idle clock must separate an update from the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Active-low synchronous reset |
| chainSel | input | 1 | This chain is selected by the surrounding test logic |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| busAddr | output | 7 | Register address toward the target |
| busWrData | output | 32 | Write data toward the target |
| busWrEn | output | 1 | One-cycle write strobe |
| busRdEn | output | 1 | One-cycle read strobe |
| busRdData | input | 32 | Read data from the target, valid while `busRdEn` is high |

## Verification
The hardest case to reach from the ports is a side-effecting register read several times in a row. This is the case where reading the same register twice, or returning results one scan late, would go unnoticed against an ordinary register. The bench models a target in which one address is a counter that advances on every read. It issues a run of back-to-back reads of that address and ends the run with an identification read. It then requires consecutive counter values, one per scan, and a total advance equal to the number of requests. A write scan placed between reads, and a period of strobe activity while deselected, check that the held read word survives both.

// File: rtl/scanRegPkg.sv
package scanRegPkg;
  typedef struct packed {
    logic capture;   // reload chain from the read latch
    logic shift;     // shift chain by one bit
    logic wrIssue;   // launch a bus write next cycle
    logic rdIssue;   // launch a bus read next cycle
    logic rdLatch;   // bus read in progress: latch returned data
  } scanStrobes_t;
endpackage

// File: rtl/scanRegCtrl.sv
module scanRegCtrl
  import scanRegPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         chainSel,
  input  logic         captureDr,
  input  logic         shiftDr,
  input  logic         updateDr,
  input  logic         rwBit,
  output scanStrobes_t strobes
);
  logic doCapture, doShift, doUpdate;
  logic rdPending;

  // Capture has priority over shift, and shift over update
  always_comb begin
    doCapture = chainSel && captureDr;
    doShift   = chainSel && shiftDr && !captureDr;
    doUpdate  = chainSel && updateDr && !captureDr && !shiftDr;
  end

  // Tracks the cycle in which the bus read is outstanding
  always_ff @(posedge clk) begin
    if (!rstN) rdPending <= 1'b0;
    else       rdPending <= doUpdate && !rwBit;
  end

  always_comb begin
    strobes.capture = doCapture;
    strobes.shift   = doShift;
    strobes.wrIssue = doUpdate && rwBit;
    strobes.rdIssue = doUpdate && !rwBit;
    strobes.rdLatch = rdPending;
  end
endmodule

// File: rtl/scanRegDatapath.sv
module scanRegDatapath
  import scanRegPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobes_t      strobes,
  input  logic              tdi,
  output logic              chainOut,
  output logic              rwBit,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWrEn,
  output logic              busRdEn,
  input  logic [DATA_W-1:0] busRdData
);
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int RW_POS  = CHAIN_W - 1;

  logic [CHAIN_W-1:0] chainReg;
  logic [DATA_W-1:0]  readHold;
  logic [ADDR_W-1:0]  fieldAddr;
  logic [DATA_W-1:0]  fieldData;

  assign fieldData = chainReg[DATA_W-1:0];
  assign fieldAddr = chainReg[DATA_W +: ADDR_W];
  assign rwBit     = chainReg[RW_POS];
  assign chainOut  = chainReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainReg <= '0;
    end else if (strobes.capture) begin
      chainReg <= {{(CHAIN_W-DATA_W){1'b0}}, readHold};
    end else if (strobes.shift) begin
      chainReg <= {tdi, chainReg[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busWrEn   <= 1'b0;
      busRdEn   <= 1'b0;
      busAddr   <= '0;
      busWrData <= '0;
    end else begin
      busWrEn <= strobes.wrIssue;
      busRdEn <= strobes.rdIssue;
      if (strobes.wrIssue || strobes.rdIssue) busAddr <= fieldAddr;
      if (strobes.wrIssue) busWrData <= fieldData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                readHold <= '0;
    else if (strobes.rdLatch) readHold <= busRdData;
  end
endmodule

// File: rtl/scanRegPort.sv
module scanRegPort
  import scanRegPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainSel,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWrEn,
  output logic              busRdEn,
  input  logic [DATA_W-1:0] busRdData
);
  scanStrobes_t strobes;
  logic rwBit;
  logic chainOut;

  scanRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .chainSel(chainSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .rwBit(rwBit), .strobes(strobes)
  );

  scanRegDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tdi(tdi), .chainOut(chainOut),
    .rwBit(rwBit), .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdData(busRdData)
  );

  // Pass-through when another chain is selected
  assign tdo = chainSel ? chainOut : tdi;
endmodule

// File: rtl/scanRegPortChk.sv
module scanRegPortChk (
  input logic clk,
  input logic rstN,
  input logic chainSel,
  input logic captureDr,
  input logic shiftDr,
  input logic updateDr,
  input logic busWrEn,
  input logic busRdEn
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> !busWrEn); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> !busRdEn); // R3
  AST_NO_WR_RD_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn)); // R2
  AST_RD_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> $past(chainSel && updateDr)); // R3
  AST_WR_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> $past(chainSel && updateDr)); // R2
  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (!chainSel || !updateDr || captureDr || shiftDr) |=> !(busWrEn || busRdEn)); // R7
endmodule

bind scanRegPort scanRegPortChk u_chk (.*);

// File: tb/scanRegPort_test.sv
module scanRegPort_test;
  localparam int FIFO_ADDR = 5;
  localparam logic [31:0] ID_WORD = 32'h4A5C_0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chainSel = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [6:0]  busAddr;
  logic [31:0] busWrData, busRdData;
  logic busWrEn, busRdEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  scanRegPort uut (
    .clk(clk), .rstN(rstN), .chainSel(chainSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdData(busRdData)
  );

  // Behavioural target: plain registers plus one counter that advances per read
  logic [31:0] regs [128];
  logic [31:0] fifoCnt = 32'h100;
  int fifoReads = 0;

  function automatic logic [31:0] tgtRead(input int a);
    return (a == FIFO_ADDR) ? fifoCnt : regs[a];
  endfunction

  assign busRdData = busRdEn ? tgtRead(int'(busAddr)) : 32'h0;

  always @(posedge clk) begin
    if (busRdEn && busAddr == FIFO_ADDR) begin
      fifoCnt <= fifoCnt + 1;
      fifoReads <= fifoReads + 1;
    end
    if (busWrEn) regs[busAddr] <= busWrData;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model: the chain as a bit queue, front is the serial output
  bit mq[$];
  logic [31:0] mLatch;
  logic [31:0] mData;
  int mAddr;
  bit mWr, mRd;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mq.delete();
      for (int i = 0; i < 40; i++) mq.push_back(1'b0);
      mLatch = '0; mWr = 0; mRd = 0; mAddr = 0; mData = '0;
    end else begin
      bit nWr, nRd;
      nWr = 0; nRd = 0;
      if (mRd) mLatch = tgtRead(mAddr);
      if (chainSel) begin
        if (captureDr) begin
          mq.delete();
          for (int i = 0; i < 32; i++) mq.push_back(mLatch[i]);
          for (int i = 0; i < 8; i++) mq.push_back(1'b0);
        end else if (shiftDr) begin
          void'(mq.pop_front());
          mq.push_back(tdi);
        end else if (updateDr) begin
          int a;
          a = 0;
          for (int i = 0; i < 7; i++) if (mq[32+i]) a += (1 << i);
          mAddr = a;
          if (mq[39]) begin
            nWr = 1;
            for (int i = 0; i < 32; i++) mData[i] = mq[i];
          end else begin
            nRd = 1;
          end
        end
      end
      mWr = nWr; mRd = nRd;
    end
  end

  // Cycle-by-cycle comparison, away from both clock edges
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      chk(tdo === (chainSel ? mq[0] : tdi), "R1/R7 tdo", 32'(tdo), 32'(chainSel ? mq[0] : tdi));
      chk(busWrEn === mWr, "R2 busWrEn", 32'(busWrEn), 32'(mWr));
      chk(busRdEn === mRd, "R3 busRdEn", 32'(busRdEn), 32'(mRd));
      if (mWr || mRd) chk(busAddr === 7'(mAddr), "R2/R3 busAddr", 32'(busAddr), 32'(mAddr));
      if (mWr) chk(busWrData === mData, "R2 busWrData", busWrData, mData);
    end
  end

  task automatic scanOp(input bit rw, input int addr, input logic [31:0] d, output logic [31:0] got);
    logic [6:0] a7;
    a7 = 7'(addr);
    got = '0;
    @(negedge clk); chainSel = 1; captureDr = 1; shiftDr = 0; updateDr = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); captureDr = 0; shiftDr = 1;
      tdi = (i < 32) ? d[i] : (i < 39) ? a7[i-32] : rw;
      #1;
      if (i < 32) got[i] = tdo;
    end
    @(negedge clk); shiftDr = 0; updateDr = 1; tdi = 0;
    @(negedge clk); updateDr = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int fifoStart;
    for (int i = 0; i < 128; i++) regs[i] = 32'h1111_0000 + 32'(i * 7);
    regs[0] = ID_WORD;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk); #2;
    chk(busWrEn === 0 && busRdEn === 0, "R8 no strobes after reset", {busWrEn, busRdEn}, 0);

    // R8: first capture after reset returns zero; R2 write
    scanOp(1, 10, 32'hDEAD_BEEF, got);
    chk(got === 32'h0, "R8 first capture", got, 32'h0);
    chk(regs[10] === 32'hDEAD_BEEF, "R2 write reached target", regs[10], 32'hDEAD_BEEF);

    // R3/R4: read 10 then identification read
    scanOp(0, 10, 32'hFFFF_FFFF, got);
    chk(got === 32'h0, "R4 no read yet", got, 32'h0);
    scanOp(0, 0, 32'h0, got);
    chk(got === 32'hDEAD_BEEF, "R3/R4 read returned next scan", got, 32'hDEAD_BEEF);
    scanOp(0, 0, 32'h0, got);
    chk(got === ID_WORD, "R4 identification", got, ID_WORD);

    // R5: write between reads leaves held word unchanged
    scanOp(0, 33, 32'h0, got);
    scanOp(1, 20, 32'h0BAD_F00D, got);
    chk(got === regs[33], "R5 write scan returns prior read", got, regs[33]);
    scanOp(0, 0, 32'h0, got);
    chk(got === regs[33], "R5 held word survives write", got, regs[33]);
    chk(regs[20] === 32'h0BAD_F00D, "R2 second write", regs[20], 32'h0BAD_F00D);

    // R6: back-to-back reads of the side-effecting register
    fifoStart = int'(fifoCnt);
    scanOp(0, FIFO_ADDR, 32'h0, got);
    for (int k = 0; k < 4; k++) begin
      scanOp(0, FIFO_ADDR, 32'h0, got);
      chk(got === 32'(fifoStart + k), "R6 burst value", got, 32'(fifoStart + k));
    end
    scanOp(0, 0, 32'h0, got);
    chk(got === 32'(fifoStart + 4), "R6 last burst value", got, 32'(fifoStart + 4));
    chk(int'(fifoCnt) == fifoStart + 5, "R6 one access per scan", fifoCnt, 32'(fifoStart + 5));

    // R7: deselected strobes have no effect
    scanOp(0, 77, 32'h0, got);
    @(negedge clk); chainSel = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      captureDr = (k % 6 == 0); shiftDr = (k % 6 == 2) || (k % 6 == 3);
      updateDr = (k % 6 == 4); tdi = k[0] ^ k[2];
      #1;
      chk(tdo === tdi, "R7 pass-through", 32'(tdo), 32'(tdi));
    end
    @(negedge clk); captureDr = 0; shiftDr = 0; updateDr = 0;
    scanOp(0, 0, 32'h0, got);
    chk(got === regs[77], "R7 held word kept while deselected", got, regs[77]);

    // R9: capture wins over shift and update in the same cycle
    @(negedge clk); chainSel = 1; captureDr = 1; shiftDr = 1; updateDr = 1; tdi = 1;
    @(negedge clk); captureDr = 0; shiftDr = 0; updateDr = 0; tdi = 0;
    #1;
    chk(tdo === ID_WORD[0], "R9 capture priority", 32'(tdo), 32'(ID_WORD[0]));
    @(negedge clk);
    chk(busRdEn === 0 && busWrEn === 0, "R9 no update with capture", {busWrEn, busRdEn}, 0);
    scanOp(0, 0, 32'h0, got);
    chk(got === ID_WORD, "R1 full round trip", got, ID_WORD);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule